// File: doc/BRIEF.md
# Vector Coprocessor Data Register Bank

This block is the data-side register bank of a fixed-point vector coprocessor. It holds 32 addressable 32-bit locations behind a 5-bit address, a write strobe with write data, and a combinational read port. Most locations are plain storage. Some are narrowed to 16 bits and return sign- or zero-extended values. Others are views computed on the fly.

Three small shift structures live inside the bank. The first is a screen XY history of three entries. It has an extra address that reads as the newest entry, and a write to that address pushes the history. The second is a screen depth history of four entries. The third is a colour history of three entries. An arithmetic datapath pushes results into each history through dedicated side ports. In the same clock, the processor bus may still overwrite any single entry directly.

Two derived views complete the bank. A packed 5:5:5 colour address expands into the three 16-bit vector accumulators on write and clamps them back on read. A count address returns the run length of leading sign bits of a source word.

Top module: `vec_dreg_file`

## Requirements
- R1: After the asynchronous active-low reset, every address reads 0, except address 31, which reads 32.
- R2: Address 15 reads the newest XY entry (address 14). Writing address 15 moves 13 into 12 and 14 into 13, and loads 14 with the write data, in one clock.
- R3: Writing address 12, 13 or 14 changes only that XY entry.
- R4: Addresses 16..19 store unsigned 16-bit depth values, with 19 the newest. They read with bits 31:16 zero, and a direct write changes only the addressed entry.
- R5: Addresses 1, 3, 5, 8, 9, 10 and 11 keep only bits 15:0 of a write, without any saturation. They read back sign-extended to 32 bits.
- R6: Writing address 28 loads address 9 with bits 4:0 times 80h, address 10 with bits 9:5 times 80h, and address 11 with bits 14:10 times 80h. Bits 31:15 of the write are ignored.
- R7: Addresses 28 and 29 both read the packed value of the accumulators 9, 10 and 11. Each value is divided by 80h (truncating) and clamped to 0..1Fh, with negative values giving 0. The results are placed at bits 4:0, 9:5 and 14:10, and bits 31:15 read zero.
- R8: Address 31 reads the number of leading bits of address 30 that equal its bit 31. The result is always 1..32.
- R9: Writes to addresses 29 and 31 have no effect on any state.
- R10: Addresses 20..22 (colour history, 22 newest) and 23 (spare) are full 32-bit storage, and a direct write to them never shifts anything. Addresses 0, 2, 4, 6 and 24..27 are also full 32-bit storage, and address 7 is unsigned 16-bit with bits 31:16 reading zero.
- R11: A side-port push on the XY, depth or colour history moves each entry one place toward the oldest and loads the newest entry with the push data, in one clock.
- R12: When a bus write addresses a history entry in the same clock as a push, that entry takes the bus data while the other entries still shift. A write to address 15 together with an XY push gives a single shift that loads the bus data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Bus write strobe |
| addr_i | input | 5 | Bus address for read and write |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| xy_push_i | input | 1 | Datapath push into XY history |
| xy_push_data_i | input | 32 | Packed Y:X pair to push |
| z_push_i | input | 1 | Datapath push into depth history |
| z_push_data_i | input | 16 | Depth value to push |
| col_push_i | input | 1 | Datapath push into colour history |
| col_push_data_i | input | 32 | Colour and code word to push |

## Verification
The hardest case to reach is a push and a bus write to the same history landing on the same clock edge. In that case the addressed entry must take the bus data while its neighbours shift past it. The bench raises the XY push strobe on the same falling edge on which it issues a direct write to the middle entry. It then reads all three entries and checks that the oldest entry holds the old middle value, the middle holds the bus data and the newest holds the push data. The count view's extremes are also driven on purpose: all zeros, all ones, and a lone sign bit.

// File: rtl/vdrf_pkg.sv
package vdrf_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int HALF_W = DATA_W / 2;

  localparam logic [ADDR_W-1:0] A_V0XY  = 5'd0;
  localparam logic [ADDR_W-1:0] A_V0Z   = 5'd1;
  localparam logic [ADDR_W-1:0] A_V1XY  = 5'd2;
  localparam logic [ADDR_W-1:0] A_V1Z   = 5'd3;
  localparam logic [ADDR_W-1:0] A_V2XY  = 5'd4;
  localparam logic [ADDR_W-1:0] A_V2Z   = 5'd5;
  localparam logic [ADDR_W-1:0] A_COLC  = 5'd6;
  localparam logic [ADDR_W-1:0] A_ORDZ  = 5'd7;
  localparam logic [ADDR_W-1:0] A_ACC0  = 5'd8;
  localparam logic [ADDR_W-1:0] A_ACC1  = 5'd9;
  localparam logic [ADDR_W-1:0] A_ACC2  = 5'd10;
  localparam logic [ADDR_W-1:0] A_ACC3  = 5'd11;
  localparam logic [ADDR_W-1:0] A_XY0   = 5'd12;
  localparam logic [ADDR_W-1:0] A_XYM   = 5'd15;
  localparam logic [ADDR_W-1:0] A_Z0    = 5'd16;
  localparam logic [ADDR_W-1:0] A_COL0  = 5'd20;
  localparam logic [ADDR_W-1:0] A_SPARE = 5'd23;
  localparam logic [ADDR_W-1:0] A_SUM0  = 5'd24;
  localparam logic [ADDR_W-1:0] A_PKIN  = 5'd28;
  localparam logic [ADDR_W-1:0] A_PKOUT = 5'd29;
  localparam logic [ADDR_W-1:0] A_CSRC  = 5'd30;
  localparam logic [ADDR_W-1:0] A_CRES  = 5'd31;
endpackage

// File: rtl/shift_stack.sv
module shift_stack #(
  parameter int DEPTH = 3,
  parameter int W     = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      push_i,
  input  logic [W-1:0]              push_data_i,
  input  logic [DEPTH-1:0]          wr_en_i,
  input  logic [W-1:0]              wr_data_i,
  output logic [DEPTH-1:0][W-1:0]   q_o
);
  // index 0 oldest, DEPTH-1 newest
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [W-1:0] nxt;
    if (i == DEPTH - 1) begin : g_top
      assign nxt = push_data_i;
    end else begin : g_mid
      assign nxt = q_o[i+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q_o[i] <= '0;
      else if (wr_en_i[i]) q_o[i] <= wr_data_i;
      else if (push_i)     q_o[i] <= nxt;
    end
  end
endmodule

// File: rtl/rgb15_conv.sv
module rgb15_conv #(
  parameter int CH_W     = 5,
  parameter int VAL_W    = 16,
  parameter int SCALE_SH = 7
) (
  input  logic [3*CH_W-1:0]        packed_i,
  input  logic [2:0][VAL_W-1:0]    val_i,
  output logic [2:0][VAL_W-1:0]    exp_o,
  output logic [3*CH_W-1:0]        packed_o
);
  localparam int PAD_W  = VAL_W - CH_W - SCALE_SH;
  localparam int CH_MAX = (1 << CH_W) - 1;

  for (genvar c = 0; c < 3; c++) begin : g_ch
    logic [VAL_W-1:0] shr;
    assign exp_o[c] = {{PAD_W{1'b0}}, packed_i[c*CH_W +: CH_W], {SCALE_SH{1'b0}}};
    assign shr = val_i[c] >> SCALE_SH;
    always_comb begin
      if (val_i[c][VAL_W-1])           packed_o[c*CH_W +: CH_W] = '0;
      else if (shr > VAL_W'(CH_MAX))   packed_o[c*CH_W +: CH_W] = CH_W'(CH_MAX);
      else                             packed_o[c*CH_W +: CH_W] = shr[CH_W-1:0];
    end
  end
endmodule

// File: rtl/lead_sign_cnt.sv
module lead_sign_cnt #(
  parameter int W     = 32,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     val_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W-1:0] diff;
  assign diff = val_i ^ {W{val_i[W-1]}};

  always_comb begin
    logic found;
    found = 1'b0;
    cnt_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && !diff[i]) cnt_o = cnt_o + CNT_W'(1);
      else                    found = 1'b1;
    end
  end
endmodule

// File: rtl/vec_dreg_file.sv
module vec_dreg_file
  import vdrf_pkg::*;
#(
  parameter int XY_DEPTH  = 3,
  parameter int Z_DEPTH   = 4,
  parameter int COL_DEPTH = 3,
  parameter int CH_W      = 5,
  parameter int SCALE_SH  = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               xy_push_i,
  input  logic [DATA_W-1:0]  xy_push_data_i,
  input  logic               z_push_i,
  input  logic [HALF_W-1:0]  z_push_data_i,
  input  logic               col_push_i,
  input  logic [DATA_W-1:0]  col_push_data_i
);
  localparam int PK_W  = 3 * CH_W;
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int NVEC  = 3;
  localparam int NSUM  = 4;

  logic [NVEC-1:0][DATA_W-1:0] vxy_q;
  logic [NVEC-1:0][HALF_W-1:0] vz_q;
  logic [DATA_W-1:0]           colc_q, spare_q, csrc_q;
  logic [HALF_W-1:0]           ordz_q, acc0_q;
  logic [2:0][HALF_W-1:0]      acc_q;
  logic [NSUM-1:0][DATA_W-1:0] sum_q;

  logic [XY_DEPTH-1:0][DATA_W-1:0]  xy_q;
  logic [Z_DEPTH-1:0][HALF_W-1:0]   z_q;
  logic [COL_DEPTH-1:0][DATA_W-1:0] col_q;
  logic [XY_DEPTH-1:0]  xy_we;
  logic [Z_DEPTH-1:0]   z_we;
  logic [COL_DEPTH-1:0] col_we;
  logic                 xy_mirror_wr, xy_shift;
  logic [DATA_W-1:0]    xy_shift_data;

  logic [2:0][HALF_W-1:0] exp_val;
  logic [PK_W-1:0]        pk_out;
  logic [CNT_W-1:0]       lead_cnt;

  always_comb begin
    for (int i = 0; i < XY_DEPTH; i++)  xy_we[i]  = we_i && (addr_i == A_XY0 + ADDR_W'(i));
    for (int i = 0; i < Z_DEPTH; i++)   z_we[i]   = we_i && (addr_i == A_Z0 + ADDR_W'(i));
    for (int i = 0; i < COL_DEPTH; i++) col_we[i] = we_i && (addr_i == A_COL0 + ADDR_W'(i));
  end

  // mirror write acts as a push carrying bus data; bus data wins on collision
  assign xy_mirror_wr  = we_i && (addr_i == A_XYM);
  assign xy_shift      = xy_push_i || xy_mirror_wr;
  assign xy_shift_data = xy_mirror_wr ? wdata_i : xy_push_data_i;

  shift_stack #(.DEPTH(XY_DEPTH), .W(DATA_W)) u_xy (
    .clk_i, .rst_ni, .push_i(xy_shift), .push_data_i(xy_shift_data),
    .wr_en_i(xy_we), .wr_data_i(wdata_i), .q_o(xy_q)
  );

  shift_stack #(.DEPTH(Z_DEPTH), .W(HALF_W)) u_z (
    .clk_i, .rst_ni, .push_i(z_push_i), .push_data_i(z_push_data_i),
    .wr_en_i(z_we), .wr_data_i(wdata_i[HALF_W-1:0]), .q_o(z_q)
  );

  shift_stack #(.DEPTH(COL_DEPTH), .W(DATA_W)) u_col (
    .clk_i, .rst_ni, .push_i(col_push_i), .push_data_i(col_push_data_i),
    .wr_en_i(col_we), .wr_data_i(wdata_i), .q_o(col_q)
  );

  rgb15_conv #(.CH_W(CH_W), .VAL_W(HALF_W), .SCALE_SH(SCALE_SH)) u_conv (
    .packed_i(wdata_i[PK_W-1:0]), .val_i(acc_q), .exp_o(exp_val), .packed_o(pk_out)
  );

  lead_sign_cnt #(.W(DATA_W), .CNT_W(CNT_W)) u_cnt (
    .val_i(csrc_q), .cnt_o(lead_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vxy_q   <= '0;
      vz_q    <= '0;
      colc_q  <= '0;
      ordz_q  <= '0;
      acc0_q  <= '0;
      acc_q   <= '0;
      sum_q   <= '0;
      spare_q <= '0;
      csrc_q  <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        A_V0XY:  vxy_q[0] <= wdata_i;
        A_V1XY:  vxy_q[1] <= wdata_i;
        A_V2XY:  vxy_q[2] <= wdata_i;
        A_V0Z:   vz_q[0]  <= wdata_i[HALF_W-1:0];
        A_V1Z:   vz_q[1]  <= wdata_i[HALF_W-1:0];
        A_V2Z:   vz_q[2]  <= wdata_i[HALF_W-1:0];
        A_COLC:  colc_q   <= wdata_i;
        A_ORDZ:  ordz_q   <= wdata_i[HALF_W-1:0];
        A_ACC0:  acc0_q   <= wdata_i[HALF_W-1:0];
        A_ACC1:  acc_q[0] <= wdata_i[HALF_W-1:0];
        A_ACC2:  acc_q[1] <= wdata_i[HALF_W-1:0];
        A_ACC3:  acc_q[2] <= wdata_i[HALF_W-1:0];
        A_SPARE: spare_q  <= wdata_i;
        A_PKIN:  acc_q    <= exp_val;
        A_CSRC:  csrc_q   <= wdata_i;
        default: begin
          for (int i = 0; i < NSUM; i++)
            if (addr_i == A_SUM0 + ADDR_W'(i)) sum_q[i] <= wdata_i;
        end
      endcase
    end
  end

  function automatic logic [DATA_W-1:0] sext(input logic [HALF_W-1:0] v);
    return {{HALF_W{v[HALF_W-1]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] zext(input logic [HALF_W-1:0] v);
    return {{HALF_W{1'b0}}, v};
  endfunction

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_V0XY:  rdata_o = vxy_q[0];
      A_V1XY:  rdata_o = vxy_q[1];
      A_V2XY:  rdata_o = vxy_q[2];
      A_V0Z:   rdata_o = sext(vz_q[0]);
      A_V1Z:   rdata_o = sext(vz_q[1]);
      A_V2Z:   rdata_o = sext(vz_q[2]);
      A_COLC:  rdata_o = colc_q;
      A_ORDZ:  rdata_o = zext(ordz_q);
      A_ACC0:  rdata_o = sext(acc0_q);
      A_ACC1:  rdata_o = sext(acc_q[0]);
      A_ACC2:  rdata_o = sext(acc_q[1]);
      A_ACC3:  rdata_o = sext(acc_q[2]);
      A_XYM:   rdata_o = xy_q[XY_DEPTH-1];
      A_SPARE: rdata_o = spare_q;
      A_PKIN, A_PKOUT: rdata_o = DATA_W'(pk_out);
      A_CSRC:  rdata_o = csrc_q;
      A_CRES:  rdata_o = DATA_W'(lead_cnt);
      default: begin
        for (int i = 0; i < XY_DEPTH; i++)
          if (addr_i == A_XY0 + ADDR_W'(i)) rdata_o = xy_q[i];
        for (int i = 0; i < Z_DEPTH; i++)
          if (addr_i == A_Z0 + ADDR_W'(i)) rdata_o = zext(z_q[i]);
        for (int i = 0; i < COL_DEPTH; i++)
          if (addr_i == A_COL0 + ADDR_W'(i)) rdata_o = col_q[i];
        for (int i = 0; i < NSUM; i++)
          if (addr_i == A_SUM0 + ADDR_W'(i)) rdata_o = sum_q[i];
      end
    endcase
  end
endmodule

// File: rtl/dreg_file_chk.sv
module dreg_file_chk
  import vdrf_pkg::*;
(
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    we_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [DATA_W-1:0]       wdata_i,
  input logic [DATA_W-1:0]       rdata_o,
  input logic                    xy_push_i,
  input logic                    z_push_i,
  input logic [HALF_W-1:0]       z_push_data_i,
  input logic [2:0][DATA_W-1:0]  xy_q,
  input logic [3:0][HALF_W-1:0]  z_q
);
  p_mirror_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == A_XYM |-> rdata_o == xy_q[2]);

  p_mirror_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == A_XYM |=>
      xy_q[2] == $past(wdata_i) && xy_q[1] == $past(xy_q[2]) && xy_q[0] == $past(xy_q[1]));

  p_direct_local_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == A_XY0 + 5'd1 && !xy_push_i |=>
      $stable(xy_q[0]) && $stable(xy_q[2]) && xy_q[1] == $past(wdata_i));

  p_depth_upper_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i >= A_Z0 && addr_i <= A_Z0 + 5'd3 |-> rdata_o[31:16] == 16'h0);

  p_sext_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == A_ACC0 |-> rdata_o[31:16] == {16{rdata_o[15]}});

  p_pack_upper_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == A_PKOUT |-> rdata_o[31:15] == 17'h0);

  p_count_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == A_CRES |-> rdata_o != 32'h0 && rdata_o <= 32'd32);

  p_depth_push_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_push_i && !(we_i && addr_i >= A_Z0 && addr_i <= A_Z0 + 5'd3) |=>
      z_q[3] == $past(z_push_data_i) && z_q[0] == $past(z_q[1]) && z_q[2] == $past(z_q[3]));

  p_bus_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xy_push_i && we_i && addr_i == A_XY0 + 5'd1 |=>
      xy_q[1] == $past(wdata_i) && xy_q[0] == $past(xy_q[1]));
endmodule

bind vec_dreg_file dreg_file_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .xy_push_i(xy_push_i),
  .z_push_i(z_push_i), .z_push_data_i(z_push_data_i),
  .xy_q(xy_q), .z_q(z_q)
);

// File: tb/vec_dreg_file_test.sv
module vec_dreg_file_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        xy_push = 1'b0, z_push = 1'b0, col_push = 1'b0;
  logic [31:0] xy_pd = '0, col_pd = '0;
  logic [15:0] z_pd = '0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vec_dreg_file uut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .xy_push_i(xy_push), .xy_push_data_i(xy_pd),
    .z_push_i(z_push), .z_push_data_i(z_pd),
    .col_push_i(col_push), .col_push_data_i(col_pd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 32; a++)
      rd_chk("R1", 5'(a), (a == 31) ? 32'd32 : 32'd0);
  endtask

  task automatic t_xy_mirror();
    wr(5'd12, 32'h0001_000A);
    wr(5'd13, 32'h0002_000B);
    wr(5'd14, 32'h0003_000C);
    rd_chk("R3", 5'd12, 32'h0001_000A);
    rd_chk("R2", 5'd15, 32'h0003_000C);
    wr(5'd15, 32'h0004_000D);
    rd_chk("R2", 5'd12, 32'h0002_000B);
    rd_chk("R2", 5'd13, 32'h0003_000C);
    rd_chk("R2", 5'd14, 32'h0004_000D);
    wr(5'd13, 32'h0005_000E);
    rd_chk("R3", 5'd12, 32'h0002_000B);
    rd_chk("R3", 5'd13, 32'h0005_000E);
    rd_chk("R3", 5'd14, 32'h0004_000D);
  endtask

  task automatic t_depth();
    for (int i = 0; i < 4; i++) wr(5'(16 + i), 32'hFFFF_1110 + 32'(i));
    wr(5'd18, 32'hDEAD_8001);
    rd_chk("R4", 5'd16, 32'h0000_1110);
    rd_chk("R4", 5'd17, 32'h0000_1111);
    rd_chk("R4", 5'd18, 32'h0000_8001);
    rd_chk("R4", 5'd19, 32'h0000_1113);
  endtask

  task automatic t_narrow();
    wr(5'd8, 32'h1200_8900);
    rd_chk("R5", 5'd8, 32'hFFFF_8900);
    wr(5'd1, 32'hABCD_1234);
    rd_chk("R5", 5'd1, 32'h0000_1234);
    wr(5'd5, 32'h0000_F00F);
    rd_chk("R5", 5'd5, 32'hFFFF_F00F);
    wr(5'd7, 32'h8000_9ABC);
    rd_chk("R10", 5'd7, 32'h0000_9ABC);
    wr(5'd26, 32'hCAFE_F00D);
    rd_chk("R10", 5'd26, 32'hCAFE_F00D);
  endtask

  task automatic t_expand();
    wr(5'd28, 32'hFFFF_C3E3);
    rd_chk("R6", 5'd9, 32'h0000_0180);
    rd_chk("R6", 5'd10, 32'h0000_0F80);
    rd_chk("R6", 5'd11, 32'h0000_0800);
    rd_chk("R7", 5'd28, 32'h0000_43E3);
  endtask

  task automatic t_collapse();
    wr(5'd9, 32'h0000_8000);
    wr(5'd10, 32'h0000_7FFF);
    wr(5'd11, 32'h0000_0280);
    rd_chk("R7", 5'd29, 32'h0000_17E0);
    rd_chk("R7", 5'd28, 32'h0000_17E0);
    wr(5'd29, 32'h0000_7FFF);
    rd_chk("R9", 5'd9, 32'hFFFF_8000);
    rd_chk("R9", 5'd11, 32'h0000_0280);
  endtask

  task automatic t_count();
    logic [31:0] src [6] = '{32'h0, 32'hFFFF_FFFF, 32'h0001_0000,
                             32'hF000_0000, 32'h8000_0000, 32'h4000_0000};
    logic [31:0] exp [6] = '{32'd32, 32'd32, 32'd15, 32'd4, 32'd1, 32'd1};
    for (int i = 0; i < 6; i++) begin
      wr(5'd30, src[i]);
      rd_chk("R8", 5'd31, exp[i]);
    end
    wr(5'd31, 32'h0000_0005);
    rd_chk("R9", 5'd31, 32'd1);
    rd_chk("R9", 5'd30, 32'h4000_0000);
  endtask

  task automatic t_colour();
    wr(5'd20, 32'h1111_1111);
    wr(5'd21, 32'h2222_2222);
    wr(5'd22, 32'h3333_3333);
    wr(5'd23, 32'h5A5A_A5A5);
    rd_chk("R10", 5'd20, 32'h1111_1111);
    rd_chk("R10", 5'd21, 32'h2222_2222);
    rd_chk("R10", 5'd23, 32'h5A5A_A5A5);
    rd_chk("R10", 5'd22, 32'h3333_3333);
  endtask

  task automatic t_push();
    @(negedge clk);
    z_push = 1'b1; z_pd = 16'hBEEF;
    col_push = 1'b1; col_pd = 32'h4444_4444;
    xy_push = 1'b1; xy_pd = 32'h0006_0006;
    @(negedge clk);
    z_push = 1'b0; col_push = 1'b0; xy_push = 1'b0;
    rd_chk("R11", 5'd16, 32'h0000_1111);
    rd_chk("R11", 5'd17, 32'h0000_8001);
    rd_chk("R11", 5'd19, 32'h0000_BEEF);
    rd_chk("R11", 5'd20, 32'h2222_2222);
    rd_chk("R11", 5'd22, 32'h4444_4444);
    rd_chk("R11", 5'd23, 32'h5A5A_A5A5);
    rd_chk("R11", 5'd12, 32'h0005_000E);
    rd_chk("R11", 5'd15, 32'h0006_0006);
  endtask

  task automatic t_collide();
    // state before: 12=0005000E 13=00040000D 14=00060006
    @(negedge clk);
    we = 1'b1; addr = 5'd13; wdata = 32'h0007_0007;
    xy_push = 1'b1; xy_pd = 32'h0008_0008;
    @(negedge clk);
    we = 1'b0; xy_push = 1'b0;
    rd_chk("R12", 5'd12, 32'h0004_000D);
    rd_chk("R12", 5'd13, 32'h0007_0007);
    rd_chk("R12", 5'd14, 32'h0008_0008);
    @(negedge clk);
    we = 1'b1; addr = 5'd15; wdata = 32'h0009_0009;
    xy_push = 1'b1; xy_pd = 32'h000F_000F;
    @(negedge clk);
    we = 1'b0; xy_push = 1'b0;
    rd_chk("R12", 5'd12, 32'h0007_0007);
    rd_chk("R12", 5'd13, 32'h0008_0008);
    rd_chk("R12", 5'd14, 32'h0009_0009);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_xy_mirror();
    t_depth();
    t_narrow();
    t_expand();
    t_collapse();
    t_count();
    t_colour();
    t_push();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule